// File: doc/BRIEF.md
# Reloadable Down-Counting Timer

This block is a down-counter that decrements once per count event, emits a one-cycle underflow pulse when it wraps, and then reloads from a reload register. Count events come from one of two sources. The first is a prescaler that divides the system clock by a programmable ratio. The second is the falling edge of an external count pin, which is first synchronized to the system clock.

Software reaches four registers through a single-cycle write port and a combinational read port. Writes that would disturb a running stage are dropped: a new divide ratio is refused while the prescaler runs, and a new source selection or direct counter load is refused while the timer runs. The reload value can be changed at any time and takes effect at the next wrap.

The prescaler runs independently of the timer. If the timer is started while the prescaler is already running, its first decrement comes on the prescaler's next tick. The first interval can therefore be up to one tick period shorter than the steady interval.

Top module: `reload_timer`

## Requirements
- R1: After reset the control register, reload register and counter read 0, the divide ratio reads 1 and the underflow output is low.
- R2: While its run bit is set, the prescaler produces one tick every N system clocks, where N is the divide ratio and a ratio of 0 acts as 1. A tick occurs N clocks after the prescaler starts. While stopped, the prescaler produces no ticks and restarts from the beginning of a period.
- R3: A write to the divide ratio (address 1) is ignored while the prescaler run bit is set.
- R4: The counter changes only on a count event while the timer run bit (control bit 0) is set. Events seen while the timer is stopped have no effect. The counter is updated on the clock edge at which the event is present.
- R5: On a count event with the counter at 0, the counter takes the reload value (address 2), and the underflow output is high for exactly the following cycle. With a reload of 3 the counter runs 3, 2, 1, 0, 3, 2.
- R6: When control bit 2 is 1, count events are falling edges of the external pin. The counter changes at the third rising clock edge after the pin goes low. Rising edges of the pin do not count.
- R7: While the timer runs, a write to the source bit (control bit 2) or a direct counter load (address 3) is ignored. The run bits in the same control write still take effect.
- R8: A write to the reload register is accepted while the timer runs. The new value is used at the next wrap.
- R9: A timer started while the prescaler is already running takes its first count event on the prescaler's next tick, which can be fewer than N clocks after the start.
- R10: Control register layout: bit 0 is timer run, bit 1 is prescaler run, bit 2 is the source (0 = prescaler, 1 = external pin). Reads at address 3 return the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 divide ratio, 2 reload, 3 counter |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | W | Combinational read data |
| ext_pin | input | 1 | External count pin, asynchronous to clk |
| underflow | output | 1 | One-cycle pulse after the counter wraps |

## Verification
Register writes show on the read port in the cycle after their clock edge. An internal count event moves the counter on the edge that carries the prescaler tick. A pin fall moves the counter three edges after the pin changes. The underflow output is high during the cycle that follows the wrapping edge. The bench drives every input 3 ns after a rising edge and keeps a cycle-exact model that it advances on each edge. It compares the read data and the underflow output with that model 3 ns after every edge, so each result is checked in exactly the cycle it is due.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
    typedef enum logic [1:0] {
        ADR_CTL    = 2'd0,
        ADR_DIV    = 2'd1,
        ADR_RELOAD = 2'd2,
        ADR_COUNT  = 2'd3
    } reg_addr_e;

    localparam int CTL_TRUN = 0;
    localparam int CTL_PRUN = 1;
    localparam int CTL_SRC  = 2;
endpackage

// File: rtl/rtimer_prescaler.sv
module rtimer_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] ratio,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] pcnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [W-1:0] term;

    always_comb begin
        term = (ratio == '0) ? '0 : ratio - 1'b1;
        tick = run && (st_q.pcnt == term);
        st_d = st_q;
        if (!run || tick) st_d.pcnt = '0;
        else              st_d.pcnt = st_q.pcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n) (tick && ratio > 1) |=> !tick) else $error("tick spacing"); // R2
endmodule

// File: rtl/rtimer_edge.sv
module rtimer_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        fall      = st_q.prev && !st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall) else $error("fall pulse too long"); // R6
endmodule

// File: rtl/rtimer_counter.sv
module rtimer_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ce,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         uf
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         uf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.uf = 1'b0;
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (ce) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload;
                st_d.uf  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign uf    = st_q.uf;

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (!run && !load_en) |=> $stable(count)) else $error("count moved while stopped"); // R4
    AST_UF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (uf && count != '0) |=> !uf) else $error("underflow too long"); // R5
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rtimer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         ext_pin,
    output logic         underflow
);
    typedef struct packed {
        logic         trun;
        logic         prun;
        logic         src;
        logic [W-1:0] ratio;
        logic [W-1:0] reload;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic pre_tick, ext_fall, ce, load_en;
    logic [W-1:0] count;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                ADR_CTL: begin
                    cfg_d.trun = wr_data[CTL_TRUN];
                    cfg_d.prun = wr_data[CTL_PRUN];
                    if (!cfg_q.trun) cfg_d.src = wr_data[CTL_SRC];
                end
                ADR_DIV:    if (!cfg_q.prun) cfg_d.ratio = wr_data;
                ADR_RELOAD: cfg_d.reload = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cfg_q.ratio <= W'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign load_en = wr_en && (reg_addr_e'(wr_addr) == ADR_COUNT) && !cfg_q.trun;
    assign ce      = cfg_q.trun && (cfg_q.src ? ext_fall : pre_tick);

    rtimer_prescaler #(.W(W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(cfg_q.prun), .ratio(cfg_q.ratio), .tick(pre_tick)
    );

    rtimer_edge u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall(ext_fall)
    );

    rtimer_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(cfg_q.trun), .ce(ce), .load_en(load_en),
        .load_val(wr_data), .reload(cfg_q.reload), .count(count), .uf(underflow)
    );

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            ADR_CTL:    rd_data = {{(W-3){1'b0}}, cfg_q.src, cfg_q.prun, cfg_q.trun};
            ADR_DIV:    rd_data = cfg_q.ratio;
            ADR_RELOAD: rd_data = cfg_q.reload;
            default:    rd_data = count;
        endcase
    end

    AST_RATIO_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) cfg_q.prun |=> $stable(cfg_q.ratio)) else $error("ratio changed while running"); // R3
    AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) cfg_q.trun |=> $stable(cfg_q.src)) else $error("source changed while running"); // R7
endmodule

// File: tb/reload_timer_test.sv
module reload_timer_test;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n, wr_en, ext_pin, underflow;
    logic [1:0]   wr_addr, rd_addr;
    logic [W-1:0] wr_data, rd_data;

    reload_timer #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_pin(ext_pin), .underflow(underflow)
    );

    int nvec = 0;
    int nbad = 0;
    int cyc  = 0;
    string cur_req = "R1";

    // cycle model built from the requirements
    logic         m_trun, m_prun, m_src, m_uf, m_s1, m_s2, m_prev;
    logic [W-1:0] m_ratio, m_reload, m_cnt, m_pcnt;

    always @(posedge clk or negedge rst_n) begin : model
        logic tick, fall, ce, n_uf, n_trun, n_prun, n_src;
        logic [W-1:0] per, n_cnt, n_pcnt, n_ratio, n_reload;
        if (!rst_n) begin
            m_trun = 0; m_prun = 0; m_src = 0; m_uf = 0;
            m_s1 = 1; m_s2 = 1; m_prev = 1;
            m_ratio = 1; m_reload = 0; m_cnt = 0; m_pcnt = 0;
        end else begin
            per  = (m_ratio == 0) ? W'(1) : m_ratio;
            tick = m_prun && (m_pcnt == per - 1);
            fall = m_prev && !m_s2;
            ce   = m_trun && (m_src ? fall : tick);
            n_cnt = m_cnt; n_uf = 0;
            if (ce) begin
                n_uf  = (m_cnt == 0);
                n_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
            end
            n_pcnt = (!m_prun || tick) ? '0 : m_pcnt + 1;
            n_trun = m_trun; n_prun = m_prun; n_src = m_src;
            n_ratio = m_ratio; n_reload = m_reload;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        n_trun = wr_data[0]; n_prun = wr_data[1];
                        if (!m_trun) n_src = wr_data[2];
                    end
                    2'd1: if (!m_prun) n_ratio = wr_data;
                    2'd2: n_reload = wr_data;
                    default: if (!m_trun) n_cnt = wr_data;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
            m_cnt = n_cnt; m_uf = n_uf; m_pcnt = n_pcnt;
            m_trun = n_trun; m_prun = n_prun; m_src = n_src;
            m_ratio = n_ratio; m_reload = n_reload;
        end
    end

    task automatic step();
        logic [W-1:0] exp;
        @(posedge clk);
        #3;
        case (rd_addr)
            2'd0:    exp = {{(W-3){1'b0}}, m_src, m_prun, m_trun};
            2'd1:    exp = m_ratio;
            2'd2:    exp = m_reload;
            default: exp = m_cnt;
        endcase
        nvec++;
        if (rd_data !== exp) begin
            nbad++;
            $display("FAIL %s rd_data addr %0d: got %0d expected %0d", cur_req, rd_addr, rd_data, exp);
        end
        nvec++;
        if (underflow !== m_uf) begin
            nbad++;
            $display("FAIL %s underflow: got %0b expected %0b", cur_req, underflow, m_uf);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            nbad++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 50000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; ext_pin = 1;
        repeat (3) @(posedge clk);
        #3 rst_n = 1;

        // R1 reset state of every register, R10 control layout
        cur_req = "R1";
        for (int a = 0; a < 4; a++) begin rd_addr = 2'(a); step(); end

        // R2 divide ratio sweep, R5 wrap sequence with reload 3
        cur_req = "R2";
        for (int r = 0; r <= 4; r++) begin
            rd_addr = 3;
            wr(0, 0); wr(1, W'(r)); wr(2, 3); wr(3, 3);
            wr(0, 3);
            run_n(20);
        end

        // R3 ratio write refused while prescaler runs
        cur_req = "R3";
        wr(1, 7);
        rd_addr = 1; run_n(2);
        wr(0, 0); wr(1, 2); run_n(1);

        // R4 stopped timer ignores prescaler ticks
        cur_req = "R4";
        rd_addr = 3;
        wr(1, 1); wr(3, 5); wr(0, 2);
        run_n(6);
        wr(0, 3); run_n(4);

        // R5 reload sweep at full rate
        cur_req = "R5";
        for (int rl = 0; rl <= 5; rl++) begin
            wr(0, 0); wr(2, W'(rl)); wr(3, W'(rl)); wr(0, 3);
            run_n(14);
        end

        // R6 external pin falls count, rises do not
        cur_req = "R6";
        wr(0, 0); wr(2, 2); wr(3, 2); wr(0, 4); wr(0, 5);
        for (int w = 3; w <= 6; w++) begin
            ext_pin = 0; run_n(w);
            ext_pin = 1; run_n(w);
        end

        // R7 source change and counter load refused while running
        cur_req = "R7";
        wr(0, 1);
        rd_addr = 0; run_n(1);
        rd_addr = 3;
        wr(3, 9); run_n(2);
        ext_pin = 0; run_n(4); ext_pin = 1; run_n(4);

        // R8 reload update while running
        cur_req = "R8";
        wr(0, 0); wr(0, 0); wr(1, 2); wr(2, 2); wr(3, 2); wr(0, 3);
        run_n(3); wr(2, 5); run_n(20);

        // R9 timer started while prescaler already runs
        cur_req = "R9";
        wr(0, 0); wr(1, 4); wr(2, 6); wr(3, 6); wr(0, 2);
        run_n(2); wr(0, 3); run_n(12);
        wr(0, 0); wr(0, 2); run_n(1); wr(0, 3); run_n(12);

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule